// File: doc/BRIEF.md
# Binary object bounding box extractor

The unit takes one binary search region at a time, delivered pixel by pixel in raster order (row by row, left to right) with a valid strobe. During a first scan pass it derives each pixel's column and row from the running pixel count. It keeps the smallest and largest column and row seen among pixels equal to 1. Pixels equal to 0 are steered to sentinel values, so they never disturb the bounds.

When the scan pass ends, one judging cycle decides whether the box is a usable candidate. A region with no set pixel, or a box narrower or shorter than a minimum size, is rejected and the frame ends there. Otherwise the source streams the same region a second time. On that crop pass the unit writes every pixel that lies strictly inside the box into an output memory at consecutive addresses. Each write carries both the binary pixel and a parallel companion channel (for example a colour component) gated by the same bounds.

Top module: `bbox_extract`

## Requirements
- R1: Valid pixels are numbered from 0 within each pass; pixel k has column k mod WIDTH and row k / WIDTH, and the pass ends with pixel WIDTH*HEIGHT-1.
- R2: From the cycle after the judging cycle until the first pixel of the next frame, box_xmin/box_xmax/box_ymin/box_ymax equal the least and greatest column and row among the scan pixels equal to 1.
- R3: A scan pixel equal to 0 leaves all four bounds unchanged.
- R4: Each frame's bounds are computed afresh: pixels of an earlier frame have no effect on them.
- R5: The judging cycle follows the last scan pixel. done is a one-cycle pulse, and a scan with no pixel equal to 1 gives done=1 with reject=1 on the second clock edge after the last scan pixel.
- R6: A frame is rejected (done=1, reject=1 at the same edge as R5) when box_xmax-box_xmin+1 < MIN_SIZE or box_ymax-box_ymin+1 < MIN_SIZE; a box of exactly MIN_SIZE in both directions is accepted.
- R7: An accepted frame gives no done pulse after its scan; reject reads 0 from the judging edge on, and the next WIDTH*HEIGHT valid pixels form the crop pass.
- R8: In the crop pass a pixel at (x, y) is written exactly when box_xmin < x < box_xmax and box_ymin < y < box_ymax; wr_en, wr_bin and wr_aux show that pixel on the clock edge that accepts it.
- R9: Write addresses start at 0 in every crop pass and rise by one for each written pixel.
- R10: done pulses with reject=0 on the edge that accepts the last crop pixel, and the next valid pixel starts a new scan.
- R11: A rejected frame produces no write; the next valid pixel starts a new scan.
- R12: A cycle with pix_valid low advances no counter, moves no bound and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pix_valid | input | 1 | Pixel strobe |
| pix_bin | input | 1 | Binary region pixel |
| pix_aux | input | AUX_W | Companion channel pixel, used in the crop pass |
| box_xmin | output | $clog2(WIDTH) | Least column of the object |
| box_xmax | output | $clog2(WIDTH) | Greatest column of the object |
| box_ymin | output | $clog2(HEIGHT) | Least row of the object |
| box_ymax | output | $clog2(HEIGHT) | Greatest row of the object |
| wr_en | output | 1 | Output memory write strobe |
| wr_addr | output | $clog2(WIDTH*HEIGHT) | Output memory write address |
| wr_bin | output | 1 | Binary pixel being written |
| wr_aux | output | AUX_W | Companion pixel being written |
| done | output | 1 | One-cycle end-of-frame pulse |
| reject | output | 1 | Last judged frame was not a candidate |

## Verification
The bench drives an object that touches the left and top borders and one that touches the right and bottom borders. A design that used inclusive bounds or off-by-one wrapping there would write border pixels or skip the last row. Boxes of exactly MIN_SIZE and of MIN_SIZE-1 check the size threshold: a wrong comparison either accepts the thin box or rejects the minimal one. An empty frame checks that an all-zero scan is rejected rather than cropped against sentinel bounds. Frames with holes inside the object, stalls on pix_valid and consecutive frames with different objects check three more things: background pixels do not move the bounds, stalls do not advance the counters, and bounds do not leak from one frame into the next.

// File: rtl/bbx_pkg.sv
package bbx_pkg;

    typedef enum logic [1:0] {
        PH_SCAN  = 2'd0,
        PH_JUDGE = 2'd1,
        PH_CROP  = 2'd2
    } bbx_phase_e;

    // Open interval test used by the crop gate on both axes.
    function automatic logic bbx_strictly_between(input int lo, input int v, input int hi);
        return (v > lo) && (v < hi);
    endfunction

endpackage

// File: rtl/bbx_coord_gen.sv
module bbx_coord_gen #(
    parameter  int WIDTH  = 210,
    parameter  int HEIGHT = 320,
    localparam int XW     = $clog2(WIDTH),
    localparam int YW     = $clog2(HEIGHT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [XW-1:0] col,
    output logic [YW-1:0] row,
    output logic          at_first,
    output logic          at_last
);

    typedef struct packed {
        logic [XW-1:0] col;
        logic [YW-1:0] row;
    } pos_t;

    pos_t pos_d, pos_q;

    // Wrapping column/row counters replace a divide by WIDTH.
    always_comb begin
        pos_d = pos_q;
        if (step) begin
            if (pos_q.col == XW'(WIDTH - 1)) begin
                pos_d.col = '0;
                pos_d.row = (pos_q.row == YW'(HEIGHT - 1)) ? '0 : pos_q.row + 1'b1;
            end else begin
                pos_d.col = pos_q.col + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    assign col      = pos_q.col;
    assign row      = pos_q.row;
    assign at_first = (pos_q.col == '0) && (pos_q.row == '0);
    assign at_last  = (pos_q.col == XW'(WIDTH - 1)) && (pos_q.row == YW'(HEIGHT - 1));

    AST_COL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(pos_q.col) < WIDTH) && (int'(pos_q.row) < HEIGHT)); // R1
    AST_STALL_HOLDS_POS: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(pos_q)); // R12

endmodule

// File: rtl/bbx_axis_track.sv
module bbx_axis_track #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          restart,
    input  logic          hit,
    input  logic [CW-1:0] coord,
    output logic [CW-1:0] lo,
    output logic [CW-1:0] hi
);

    typedef struct packed {
        logic [CW-1:0] lo;
        logic [CW-1:0] hi;
    } ext_t;

    ext_t ext_d, ext_q;
    logic [CW-1:0] base_lo, base_hi, cand_lo, cand_hi;

    always_comb begin
        // A new frame compares against the sentinels, not the old box.
        base_lo = restart ? {CW{1'b1}} : ext_q.lo;
        base_hi = restart ? {CW{1'b0}} : ext_q.hi;
        // Background pixels present a sentinel that can never win.
        cand_lo = hit ? coord : {CW{1'b1}};
        cand_hi = hit ? coord : {CW{1'b0}};
        ext_d   = ext_q;
        if (en) begin
            ext_d.lo = (cand_lo < base_lo) ? cand_lo : base_lo;
            ext_d.hi = (cand_hi > base_hi) ? cand_hi : base_hi;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_q.lo <= {CW{1'b1}};
            ext_q.hi <= {CW{1'b0}};
        end else begin
            ext_q <= ext_d;
        end
    end

    assign lo = ext_q.lo;
    assign hi = ext_q.hi;

    AST_HIT_INSIDE_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
        en && hit |=> (lo <= $past(coord)) && (hi >= $past(coord))); // R2
    AST_BACKGROUND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        en && !hit && !restart |=> $stable(lo) && $stable(hi)); // R3
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(lo) && $stable(hi)); // R12

endmodule

// File: rtl/bbx_crop_writer.sv
module bbx_crop_writer #(
    parameter int AW    = 17,
    parameter int AUX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             restart,
    input  logic             keep,
    input  logic             in_bin,
    input  logic [AUX_W-1:0] in_aux,
    output logic             wr_en,
    output logic [AW-1:0]    wr_addr,
    output logic             wr_bin,
    output logic [AUX_W-1:0] wr_aux
);

    typedef struct packed {
        logic [AW-1:0]    cnt;
        logic             en;
        logic [AW-1:0]    addr;
        logic             bin;
        logic [AUX_W-1:0] aux;
    } wr_t;

    wr_t wr_d, wr_q;
    logic [AW-1:0] cnt_base;

    always_comb begin
        cnt_base = restart ? '0 : wr_q.cnt;
        wr_d     = wr_q;
        wr_d.en  = 1'b0;
        if (step) begin
            wr_d.cnt = cnt_base;
            if (keep) begin
                wr_d.en   = 1'b1;
                wr_d.addr = cnt_base;
                wr_d.bin  = in_bin;
                wr_d.aux  = in_aux;
                wr_d.cnt  = cnt_base + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wr_q <= '0;
        else        wr_q <= wr_d;
    end

    assign wr_en   = wr_q.en;
    assign wr_addr = wr_q.addr;
    assign wr_bin  = wr_q.bin;
    assign wr_aux  = wr_q.aux;

    AST_WRITE_NEEDS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(step && keep)); // R8
    AST_ADDR_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wr_q.cnt == wr_addr + 1'b1); // R9

endmodule

// File: rtl/bbox_extract.sv
module bbox_extract
    import bbx_pkg::*;
#(
    parameter  int WIDTH    = 210,
    parameter  int HEIGHT   = 320,
    parameter  int MIN_SIZE = 15,
    parameter  int AUX_W    = 8,
    localparam int XW       = $clog2(WIDTH),
    localparam int YW       = $clog2(HEIGHT),
    localparam int AW       = $clog2(WIDTH * HEIGHT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_valid,
    input  logic             pix_bin,
    input  logic [AUX_W-1:0] pix_aux,
    output logic [XW-1:0]    box_xmin,
    output logic [XW-1:0]    box_xmax,
    output logic [YW-1:0]    box_ymin,
    output logic [YW-1:0]    box_ymax,
    output logic             wr_en,
    output logic [AW-1:0]    wr_addr,
    output logic             wr_bin,
    output logic [AUX_W-1:0] wr_aux,
    output logic             done,
    output logic             reject
);

    localparam int MIN_SPAN = MIN_SIZE - 1;

    typedef struct packed {
        bbx_phase_e phase;
        logic       seen;
        logic       reject;
        logic       done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [XW-1:0] col;
    logic [YW-1:0] row;
    logic          at_first, at_last;
    logic          scan_step, crop_step, keep, too_small;

    bbx_coord_gen #(.WIDTH(WIDTH), .HEIGHT(HEIGHT)) u_coord (
        .clk(clk), .rst_n(rst_n), .step(scan_step | crop_step),
        .col(col), .row(row), .at_first(at_first), .at_last(at_last)
    );

    bbx_axis_track #(.CW(XW)) u_xtrk (
        .clk(clk), .rst_n(rst_n), .en(scan_step), .restart(at_first),
        .hit(pix_bin), .coord(col), .lo(box_xmin), .hi(box_xmax)
    );

    bbx_axis_track #(.CW(YW)) u_ytrk (
        .clk(clk), .rst_n(rst_n), .en(scan_step), .restart(at_first),
        .hit(pix_bin), .coord(row), .lo(box_ymin), .hi(box_ymax)
    );

    assign keep = bbx_strictly_between(int'(box_xmin), int'(col), int'(box_xmax)) &&
                  bbx_strictly_between(int'(box_ymin), int'(row), int'(box_ymax));

    bbx_crop_writer #(.AW(AW), .AUX_W(AUX_W)) u_wr (
        .clk(clk), .rst_n(rst_n), .step(crop_step), .restart(at_first),
        .keep(keep), .in_bin(pix_bin), .in_aux(pix_aux),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_bin(wr_bin), .wr_aux(wr_aux)
    );

    assign too_small = !ctl_q.seen ||
                       ((int'(box_xmax) - int'(box_xmin)) < MIN_SPAN) ||
                       ((int'(box_ymax) - int'(box_ymin)) < MIN_SPAN);

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        scan_step  = 1'b0;
        crop_step  = 1'b0;
        case (ctl_q.phase)
            PH_SCAN: begin
                if (pix_valid) begin
                    scan_step  = 1'b1;
                    ctl_d.seen = (at_first ? 1'b0 : ctl_q.seen) | pix_bin;
                    if (at_last) ctl_d.phase = PH_JUDGE;
                end
            end
            PH_JUDGE: begin
                ctl_d.reject = too_small;
                ctl_d.done   = too_small;
                ctl_d.phase  = too_small ? PH_SCAN : PH_CROP;
            end
            PH_CROP: begin
                if (pix_valid) begin
                    crop_step = 1'b1;
                    if (at_last) begin
                        ctl_d.phase = PH_SCAN;
                        ctl_d.done  = 1'b1;
                    end
                end
            end
            default: ctl_d.phase = PH_SCAN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.phase  <= PH_SCAN;
            ctl_q.seen   <= 1'b0;
            ctl_q.reject <= 1'b0;
            ctl_q.done   <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign done   = ctl_q.done;
    assign reject = ctl_q.reject;

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5
    AST_REJECT_SKIPS_CROP: assert property (@(posedge clk) disable iff (!rst_n)
        done && reject |-> ctl_q.phase == PH_SCAN); // R11
    AST_ACCEPT_MEETS_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        done && !reject |-> ((int'(box_xmax) - int'(box_xmin)) >= MIN_SPAN) &&
                            ((int'(box_ymax) - int'(box_ymin)) >= MIN_SPAN)); // R6
    AST_WRITE_ONLY_IN_CROP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(ctl_q.phase) == PH_CROP); // R11
    AST_WRITE_STRICTLY_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'($past(col)) > int'(box_xmin)) && (int'($past(col)) < int'(box_xmax)) &&
                  (int'($past(row)) > int'(box_ymin)) && (int'($past(row)) < int'(box_ymax))); // R8

endmodule

// File: tb/tb_bbox_extract.sv
`timescale 1ns/1ps
module tb_bbox_extract;

    localparam int TW   = 210;
    localparam int TH   = 24;
    localparam int TMIN = 15;
    localparam int TAUX = 8;
    localparam int NPIX = TW * TH;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pix_valid = 1'b0;
    logic pix_bin = 1'b0;
    logic [TAUX-1:0] pix_aux = '0;
    logic [$clog2(TW)-1:0] box_xmin, box_xmax;
    logic [$clog2(TH)-1:0] box_ymin, box_ymax;
    logic wr_en, wr_bin, done, reject;
    logic [$clog2(NPIX)-1:0] wr_addr;
    logic [TAUX-1:0] wr_aux;

    int total = 0;
    int fails = 0;
    bit finished = 0;

    // current object description
    bit obj_on;
    int ox0, oy0, ox1, oy1, seed;
    // expected box
    int ex0, ex1, ey0, ey1;
    bit eseen, erej;

    always #10 clk = ~clk;

    bbox_extract #(.WIDTH(TW), .HEIGHT(TH), .MIN_SIZE(TMIN), .AUX_W(TAUX)) dut (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_bin(pix_bin), .pix_aux(pix_aux),
        .box_xmin(box_xmin), .box_xmax(box_xmax), .box_ymin(box_ymin), .box_ymax(box_ymax),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_bin(wr_bin), .wr_aux(wr_aux),
        .done(done), .reject(reject)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic bit img_bin(int x, int y);
        if (!obj_on) return 1'b0;
        if (x < ox0 || x > ox1 || y < oy0 || y > oy1) return 1'b0;
        if (x == ox0 || x == ox1 || y == oy0 || y == oy1) return 1'b1;
        return ((x + 2 * y) % 5) != 0;   // holes of background inside the object
    endfunction

    function automatic logic [TAUX-1:0] img_aux(int x, int y);
        return TAUX'((x * 3 + y * 7 + seed) & 255);
    endfunction

    function automatic bit exp_keep(int x, int y);
        return (x > ex0) && (x < ex1) && (y > ey0) && (y < ey1);
    endfunction

    task automatic step_pixel(input bit v, input bit b, input logic [TAUX-1:0] a);
        pix_valid = v;
        pix_bin   = b;
        pix_aux   = a;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic send_pass(input bit crop, input bit gaps);
        int ea;
        ea = 0;
        for (int k = 0; k < NPIX; k++) begin
            int x;
            int y;
            bit kp;
            x = k % TW;
            y = k / TW;
            if (gaps && (k % 97) == 5) begin
                step_pixel(1'b0, 1'b1, 8'hFF);
                chk(wr_en == 1'b0, "R12 stall write", wr_en, 0);
                chk(done == 1'b0, "R12 stall done", done, 0);
            end
            step_pixel(1'b1, img_bin(x, y), img_aux(x, y));
            if (crop) begin
                kp = exp_keep(x, y);
                chk(wr_en == kp, "R1/R8 crop gate", wr_en, kp);
                if (kp && wr_en) begin
                    chk(int'(wr_addr) == ea, "R9 address", wr_addr, ea);
                    chk(wr_bin == img_bin(x, y), "R8 binary data", wr_bin, img_bin(x, y));
                    chk(wr_aux == img_aux(x, y), "R8 aux data", wr_aux, img_aux(x, y));
                end
                if (kp) ea++;
                chk(done == (k == NPIX - 1), "R10 crop done", done, (k == NPIX - 1));
            end else begin
                chk(wr_en == 1'b0, "R11 no write in scan", wr_en, 0);
                chk(done == 1'b0, "R5 no done in scan", done, 0);
            end
        end
        pix_valid = 1'b0;
    endtask

    task automatic check_box(input string tag);
        chk(int'(box_xmin) == ex0, tag, box_xmin, ex0);
        chk(int'(box_xmax) == ex1, tag, box_xmax, ex1);
        chk(int'(box_ymin) == ey0, tag, box_ymin, ey0);
        chk(int'(box_ymax) == ey1, tag, box_ymax, ey1);
    endtask

    task automatic run_frame(input bit on, input int x0, input int y0, input int x1,
                             input int y1, input bit gaps, input string note);
        obj_on = on; ox0 = x0; oy0 = y0; ox1 = x1; oy1 = y1; seed = x0 + y1;
        eseen = 0; ex0 = TW; ex1 = -1; ey0 = TH; ey1 = -1;
        for (int y = 0; y < TH; y++) begin
            for (int x = 0; x < TW; x++) begin
                if (img_bin(x, y)) begin
                    eseen = 1;
                    if (x < ex0) ex0 = x;
                    if (x > ex1) ex1 = x;
                    if (y < ey0) ey0 = y;
                    if (y > ey1) ey1 = y;
                end
            end
        end
        erej = !eseen || (ex1 - ex0 + 1 < TMIN) || (ey1 - ey0 + 1 < TMIN);
        $display("frame: %s", note);
        send_pass(1'b0, gaps);
        // judging edge
        step_pixel(1'b0, 1'b0, '0);
        chk(done == erej, erej ? "R5/R6 reject done" : "R7 no done on accept", done, erej);
        chk(reject == erej, erej ? "R6 reject flag" : "R7 reject clear", reject, erej);
        if (eseen) check_box("R2 R3 R4 bounds");
        if (erej) begin
            step_pixel(1'b0, 1'b0, '0);
            chk(done == 1'b0, "R5 done is a pulse", done, 0);
            chk(wr_en == 1'b0, "R11 no write after reject", wr_en, 0);
        end else begin
            send_pass(1'b1, gaps);
            chk(reject == 1'b0, "R10 reject low at end", reject, 0);
            step_pixel(1'b0, 1'b0, '0);
            chk(done == 1'b0, "R10 done is a pulse", done, 0);
            chk(wr_en == 1'b0, "R10 no write after crop", wr_en, 0);
            check_box("R2 bounds held through crop");
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R5 reset done", done, 0);
        chk(wr_en == 1'b0, "R8 reset write", wr_en, 0);
        chk(reject == 1'b0, "R6 reset reject", reject, 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_frame(1'b1, 20, 3, 60, 20, 1'b0, "mid object accepted");
        run_frame(1'b0, 0, 0, 0, 0, 1'b0, "empty region R5");
        run_frame(1'b1, 0, 0, 14, 14, 1'b0, "exact minimum at top-left R6");
        run_frame(1'b1, 100, 5, 113, 20, 1'b0, "one column short R6");
        run_frame(1'b1, 195, 8, 209, 23, 1'b1, "bottom-right with stalls R12");
        run_frame(1'b1, 50, 2, 80, 9, 1'b0, "too short R6");
        run_frame(1'b1, 30, 1, 70, 22, 1'b1, "new object after reject R4");
        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            fails++;
            $display("FAIL watchdog (all requirements): actual %0d cycles expected fewer", 200000);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule